// File: doc/BRIEF.md
# Quick Arbitration Target Sequencer

This block runs the target side of a quick bus handover: ownership of a parallel bus passes from one target to the next without first going through a bus-free phase. While quick arbitration is enabled and the target has work that needs the bus, the block watches the message-in traffic. When it sees the handover message byte acknowledged, it waits for the current owner to drop BSY. If the owner lets go in time, the block places its own ID bit on the data lines and holds it for the full decision window. It then samples the wired-OR bus value.

If this target's ID is the highest one present, the block raises SEL while keeping its ID bit asserted. It waits out the minimum delay before reselection and then signals the reselection logic with a one-cycle start pulse. A losing target drops its ID bit on the next cycle and never raises SEL.

All timing windows are set in nanoseconds and turned into clock cycles using the clock period parameter. Minimum windows round up to whole cycles and maximum windows round down. With the default 10 ns clock the release window is 20 cycles, the decision window is 100 cycles and the reselection delay is 100 cycles. The data bus is 8 lines wide, so IDs run from 0 to 7.

Top module: `qas_target_seq`

## Requirements
- R1: After a synchronous reset, `db_drive`, `sel_out` and `resel_go` are all low.
- R2: A trigger is a clock edge at which `msg_phase`, `req_in` and `ack_in` are all high and `db_in[7:0]` equals 55h, while `qas_en` and `want_bus` are both high. No other byte value and no edge without `ack_in` counts as a trigger. A trigger starts the release wait and latches `own_id`.
- R3: The owner counts as released if BSY is seen low at one of the REL_CYC = floor(200/CLK_NS) edges that follow the trigger, and the block then arbitrates. A release seen on the last of these edges still counts. If BSY is still high at all of them, the block returns to idle and drives nothing.
- R4: During arbitration, `db_drive` is exactly one-hot at bit `own_id` (bit n stands for ID n). It stays so for DEC_CYC = ceil(1000/CLK_NS) cycles with `sel_out` low.
- R5: On the last arbitration cycle the block wins exactly when the highest set bit of `db_in` is its own ID, so a higher ID always beats a lower one.
- R6: A winner asserts `sel_out` and keeps its ID bit for RES_CYC = ceil(1000/CLK_NS) cycles. It then raises `resel_go` for one cycle with `sel_out` still high, and releases all outputs on the next cycle.
- R7: A loser shows `db_drive` all zero on the cycle after the decision and never asserts `sel_out` or `resel_go`.
- R8: When `qas_en` is low, the block is idle from the next cycle with every output low, and it ignores triggers.
- R9: When `want_bus` is low, a handover message causes no arbitration and every output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qas_en | input | 1 | Quick arbitration negotiated and enabled |
| want_bus | input | 1 | Target has a pending reconnection |
| own_id | input | ID_W | This target's bus ID |
| msg_phase | input | 1 | Bus is in message-in phase |
| req_in | input | 1 | REQ line level |
| ack_in | input | 1 | ACK line level |
| bsy_in | input | 1 | BSY line level |
| db_in | input | DATA_W | Data line levels (wired-OR of all drivers) |
| db_drive | output | DATA_W | Data lines this target asserts |
| sel_out | output | 1 | SEL asserted by this target |
| resel_go | output | 1 | One-cycle start of reselection |

## Verification
Two events can fall on the same edge: the release window expiring and the owner dropping BSY. The bench provokes this by releasing BSY so that it is first seen low on the last edge of the release window. It judges the result by requiring a full arbitration of DEC_CYC cycles. A release one edge later must leave the data lines untouched. Every ID is also swept against sets of competing IDs drawn from below, above and around it, and the bench checks the win or loss it works out from the highest competing ID.

// File: rtl/qas_pkg.sv
package qas_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WREL  = 3'd1,
    S_ARB   = 3'd2,
    S_WIN   = 3'd3,
    S_RESEL = 3'd4
  } qas_st_t;

  // minimum windows: round up to whole cycles
  function automatic int cyc_min(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // maximum windows: round down, never below one cycle
  function automatic int cyc_max(input int ns, input int clk_ns);
    return (ns / clk_ns < 1) ? 1 : ns / clk_ns;
  endfunction

endpackage

// File: rtl/qas_msg_detect.sv
module qas_msg_detect #(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  MSG_CODE = 8'h55
) (
  input  logic              msg_phase,
  input  logic              req_in,
  input  logic              ack_in,
  input  logic [DATA_W-1:0] db_in,
  output logic              hit
);

  // handover byte counts only once the initiator has acknowledged it
  assign hit = msg_phase && req_in && ack_in && (db_in[7:0] == MSG_CODE);

endmodule

// File: rtl/qas_win_timer.sv
module qas_win_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign done = (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);

endmodule

// File: rtl/qas_prio_resolve.sv
module qas_prio_resolve #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic [DATA_W-1:0] bus,
  output logic [ID_W-1:0]   top_id,
  output logic              any_bit
);

  always_comb begin
    top_id  = '0;
    any_bit = |bus;
    for (int i = 0; i < DATA_W; i++) begin
      if (bus[i]) top_id = ID_W'(i);
    end
  end

endmodule

// File: rtl/qas_target_seq.sv
module qas_target_seq
  import qas_pkg::*;
#(
  parameter int         CLK_NS     = 10,
  parameter int         DATA_W     = 8,
  parameter int         ID_W       = $clog2(DATA_W),
  parameter logic [7:0] MSG_CODE   = 8'h55,
  parameter int         REL_MAX_NS = 200,
  parameter int         DEC_MIN_NS = 1000,
  parameter int         RES_MIN_NS = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qas_en,
  input  logic              want_bus,
  input  logic [ID_W-1:0]   own_id,
  input  logic              msg_phase,
  input  logic              req_in,
  input  logic              ack_in,
  input  logic              bsy_in,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_drive,
  output logic              sel_out,
  output logic              resel_go
);

  localparam int REL_CYC = cyc_max(REL_MAX_NS, CLK_NS);
  localparam int DEC_CYC = cyc_min(DEC_MIN_NS, CLK_NS);
  localparam int RES_CYC = cyc_min(RES_MIN_NS, CLK_NS);
  localparam int MAX_A   = (REL_CYC > DEC_CYC) ? REL_CYC : DEC_CYC;
  localparam int MAX_CYC = (MAX_A > RES_CYC) ? MAX_A : RES_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  qas_st_t          st_q, st_d;
  logic [ID_W-1:0]  id_q;
  logic             hit, done, any_bit, clear;
  logic [ID_W-1:0]  top_id;
  logic [CNT_W-1:0] limit;

  qas_msg_detect #(.DATA_W(DATA_W), .MSG_CODE(MSG_CODE)) u_det (
    .msg_phase(msg_phase), .req_in(req_in), .ack_in(ack_in),
    .db_in(db_in), .hit(hit)
  );

  qas_win_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .clear(clear), .limit(limit), .done(done)
  );

  qas_prio_resolve #(.DATA_W(DATA_W), .ID_W(ID_W)) u_prio (
    .bus(db_in), .top_id(top_id), .any_bit(any_bit)
  );

  always_comb begin
    case (st_q)
      S_WREL:  limit = CNT_W'(REL_CYC);
      S_ARB:   limit = CNT_W'(DEC_CYC);
      S_WIN:   limit = CNT_W'(RES_CYC);
      default: limit = CNT_W'(1);
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (!qas_en) begin
      st_d = S_IDLE;
    end else begin
      case (st_q)
        S_IDLE:  if (hit && want_bus) st_d = S_WREL;
        S_WREL:  if (!bsy_in) st_d = S_ARB;
                 else if (done) st_d = S_IDLE;
        S_ARB:   if (done) st_d = (any_bit && top_id == id_q) ? S_WIN : S_IDLE;
        S_WIN:   if (done) st_d = S_RESEL;
        S_RESEL: st_d = S_IDLE;
        default: st_d = S_IDLE;
      endcase
    end
  end

  // each window restarts from zero whenever the state moves
  assign clear = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      id_q     <= '0;
      db_drive <= '0;
      sel_out  <= 1'b0;
      resel_go <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && st_d == S_WREL) id_q <= own_id;
      db_drive <= (st_d == S_ARB || st_d == S_WIN || st_d == S_RESEL)
                  ? (DATA_W'(1) << id_q) : '0;
      sel_out  <= (st_d == S_WIN || st_d == S_RESEL);
      resel_go <= (st_d == S_RESEL);
    end
  end

  a_r4_single_id: assert property (@(posedge clk) disable iff (rst)
    $onehot0(db_drive));

  a_r6_sel_keeps_id: assert property (@(posedge clk) disable iff (rst)
    sel_out |-> (db_drive != '0));

  a_r5_sel_after_arb: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_out) |-> $past(st_q == S_ARB));

  a_r6_resel_under_sel: assert property (@(posedge clk) disable iff (rst)
    resel_go |-> (sel_out && $past(sel_out)));

  a_r8_disable_release: assert property (@(posedge clk) disable iff (rst)
    !qas_en |=> (db_drive == '0 && !sel_out && !resel_go));

endmodule

// File: tb/qas_target_seq_test.sv
module qas_target_seq_test;

  localparam int CLK_NS = 10;
  localparam int DW     = 8;
  localparam int REL    = 200 / CLK_NS;
  localparam int DEC    = (1000 + CLK_NS - 1) / CLK_NS;
  localparam int RES    = (1000 + CLK_NS - 1) / CLK_NS;

  logic          clk = 0, rst = 1;
  logic          qas_en = 0, want_bus = 0;
  logic [2:0]    own_id = 0;
  logic          msg_phase = 0, req_in = 0, ack_in = 0, bsy_in = 1;
  logic [DW-1:0] msg_byte = 0, comp = 0;
  logic [DW-1:0] db_drive, db_in;
  logic          sel_out, resel_go;
  int vectors = 0, errs = 0;

  assign db_in = db_drive | comp | msg_byte;

  always #5 clk = ~clk;

  qas_target_seq #(.CLK_NS(CLK_NS), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .qas_en(qas_en), .want_bus(want_bus),
    .own_id(own_id), .msg_phase(msg_phase), .req_in(req_in),
    .ack_in(ack_in), .bsy_in(bsy_in), .db_in(db_in),
    .db_drive(db_drive), .sel_out(sel_out), .resel_go(resel_go)
  );

  task automatic chk(input string rq, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic send_msg(input logic [7:0] code, input logic ack);
    @(negedge clk);
    msg_phase = 1; req_in = 1; ack_in = ack; msg_byte = code; bsy_in = 1;
    @(negedge clk);
    msg_phase = 0; req_in = 0; ack_in = 0; msg_byte = 0;
  endtask

  // runs one handover; returns counted cycles of each output phase
  task automatic handover(input int own, input logic [DW-1:0] mask,
                          input logic [7:0] code, input logic ack,
                          input int rel_delay,
                          output int n_arb, output int n_sel,
                          output int n_res, output int n_bad);
    own_id = own[2:0];
    send_msg(code, ack);
    for (int i = 1; i < rel_delay; i++) @(negedge clk);
    bsy_in = 0;
    comp = mask;
    n_arb = 0; n_sel = 0; n_res = 0; n_bad = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (db_drive == 0 && !sel_out && !resel_go) break;
      if (db_drive != (DW'(1) << own)) n_bad++;
      if (!sel_out) begin
        if (resel_go) n_bad++;
        n_arb++;
      end else if (!resel_go) n_sel++;
      else n_res++;
    end
    comp = 0;
    bsy_in = 1;
  endtask

  function automatic int highest(input logic [DW-1:0] m);
    int h = -1;
    for (int i = 0; i < DW; i++) if (m[i]) h = i;
    return h;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    int a, s, r, b;
    logic [DW-1:0] m;
    logic [DW-1:0] masks [5];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 drive", int'(db_drive), 0);
    chk("R1 sel", int'(sel_out), 0);
    chk("R1 resel", int'(resel_go), 0);
    rst = 0; qas_en = 1; want_bus = 1;

    // R4 R5 R6 R7 sweep over every ID and competitor sets
    for (int id = 0; id < DW; id++) begin
      masks[0] = '0;
      masks[1] = '1;
      masks[2] = (DW'(1) << id) - 1;
      masks[3] = (id < DW - 1) ? (DW'(1) << (id + 1)) : DW'(1);
      masks[4] = 8'b0010_0101;
      for (int k = 0; k < 5; k++) begin
        m = masks[k] & ~(DW'(1) << id);
        handover(id, m, 8'h55, 1'b1, 1 + (k % 3), a, s, r, b);
        chk("R4 arbitration cycles", a, DEC);
        chk("R4 only own bit", b, 0);
        if (id > highest(m)) begin
          chk("R6 win sel cycles", s, RES);
          chk("R6 resel pulse", r, 1);
        end else begin
          chk("R7 loser no sel", s, 0);
          chk("R7 loser no resel", r, 0);
        end
        chk("R7 released after", int'(db_drive) + int'(sel_out), 0);
      end
    end

    // R3 release seen on last edge of the window still arbitrates
    handover(3, 8'h05, 8'h55, 1'b1, REL, a, s, r, b);
    chk("R3 release at window edge", a, DEC);
    chk("R3 then wins", s, RES);
    // R3 release one edge late: nothing driven
    handover(3, 8'h05, 8'h55, 1'b1, REL + 1, a, s, r, b);
    chk("R3 late release", a + s + r, 0);

    // R2 wrong code and missing acknowledge are ignored
    handover(6, 8'h00, 8'h54, 1'b1, 1, a, s, r, b);
    chk("R2 wrong code", a + s + r, 0);
    handover(6, 8'h00, 8'h55, 1'b0, 1, a, s, r, b);
    chk("R2 no ack", a + s + r, 0);

    // R9 no pending work
    want_bus = 0;
    handover(6, 8'h00, 8'h55, 1'b1, 1, a, s, r, b);
    chk("R9 want_bus low", a + s + r, 0);
    want_bus = 1;

    // R8 disabled ignores trigger
    qas_en = 0;
    handover(6, 8'h00, 8'h55, 1'b1, 1, a, s, r, b);
    chk("R8 disabled", a + s + r, 0);
    qas_en = 1;

    // R8 disable in the middle of arbitration
    own_id = 2;
    send_msg(8'h55, 1'b1);
    bsy_in = 0;
    repeat (10) @(negedge clk);
    chk("R8 arbitrating before drop", int'(db_drive), 4);
    qas_en = 0;
    @(negedge clk);
    chk("R8 released after drop", int'(db_drive) + int'(sel_out), 0);
    bsy_in = 1; qas_en = 1;
    repeat (2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule